// File: doc/BRIEF.md
# Bit-Band Alias Access Unit

This unit sits between a 32-bit memory-mapped bus master and a word-wide synchronous single-port SRAM. It decodes two address windows. The direct window reaches the SRAM as a byte array, with byte, half-word and word accesses. The alias window is 32 times larger. Each of its words stands for one bit of one SRAM byte.

A read of an alias word returns that bit, zero-extended to 32 bits. A write to an alias word becomes a locked read-modify-write. The unit fetches the containing word, replaces the one bit, and writes back only the byte lane that holds it.

The master uses a request/ready handshake. Read data arrives with a one-cycle valid strobe. Addresses outside both windows are accepted but never reach the SRAM.

Top module: `bitband_alias_unit`

## Requirements
- R1: An alias address equal to ALIAS_BASE + 32*k + 4*b, with b in 0..7, selects bit b of the byte at REAL_BASE + k. Within the SRAM word k/4 that byte sits in lane k mod 4, little-endian, so lane 0 is bits 7:0. With the defaults, 0x22006008 selects bit 2 of the byte at 0x20000300.
- R2: An alias read returns 0x00000001 when the selected bit is set and 0x00000000 when it is clear. m_rvalid goes high in the second cycle after the request is accepted.
- R3: An alias write sets the selected bit to m_wdata[0]. Bits 31:1 of the write data are ignored, and every other bit of the SRAM word keeps its value.
- R4: In the cycle after an alias access is accepted, m_ready is low, so no other request can enter. The write-back of an alias write asserts exactly one byte enable, the lane of the target byte, on the same SRAM word that was read.
- R5: Direct writes use m_size: 0 for a byte, 1 for a half-word, 2 or 3 for a word. Write data is taken from the low bits of m_wdata. A byte goes to lane addr[1:0]. A half-word goes to lanes 1:0 when addr[1]=0 and to lanes 3:2 when addr[1]=1. Other lanes are untouched.
- R6: A direct read returns the full stored word with m_rvalid in the first cycle after acceptance. m_ready stays high, so there are no wait states.
- R7: An access outside both windows never asserts sram_en. A read of such an address returns zero with m_rvalid one cycle after acceptance.
- R8: After reset, m_ready is high while m_rvalid and sram_en are low.
- R9: The last byte of the direct window can be reached through both windows. The first address past each window is treated as outside both windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_req | input | 1 | Master request |
| m_we | input | 1 | Request is a write |
| m_size | input | 2 | Access size: 0 byte, 1 half-word, 2/3 word |
| m_addr | input | 32 | Byte address |
| m_wdata | input | 32 | Write data, low-aligned |
| m_ready | output | 1 | Request accepted on this edge when high with m_req |
| m_rvalid | output | 1 | Read data valid |
| m_rdata | output | 32 | Read data |
| sram_en | output | 1 | SRAM access enable |
| sram_we | output | 1 | SRAM write enable |
| sram_be | output | 4 | SRAM byte enables |
| sram_addr | output | AW | SRAM word address |
| sram_wdata | output | 32 | SRAM write data |
| sram_rdata | input | 32 | SRAM read data, valid the cycle after an enabled read |

## Verification
The bench keeps the default parameters: a 4096-byte direct window at 0x20000000 and its 128 KiB alias window at 0x22000000. This puts the worked address 0x22006008 inside the alias window. The top byte 0xFFF and its alias word 0x2201FFFC can be probed next to the first out-of-window addresses 0x20001000 and 0x22020000. The small depth also lets the bench keep a full shadow of the SRAM and check every alias result against direct reads.

// File: rtl/bb_pkg.sv
package bb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ALIAS_RD = 2'd1,
        ST_ALIAS_WB = 2'd2
    } bb_state_e;

    typedef enum logic [1:0] {
        RSP_SRAM = 2'd0,
        RSP_BIT  = 2'd1,
        RSP_ZERO = 2'd2
    } bb_resp_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

endpackage

// File: rtl/bb_addr_decode.sv
module bb_addr_decode #(
    parameter logic [31:0] REAL_BASE  = 32'h2000_0000,
    parameter logic [31:0] ALIAS_BASE = 32'h2200_0000,
    parameter int unsigned REAL_BYTES = 4096,
    localparam int BW = $clog2(REAL_BYTES)
) (
    input  logic [31:0]   addr,
    output logic          hit_real,
    output logic          hit_alias,
    output logic [BW-1:0] byte_off,
    output logic [2:0]    bitpos
);
    localparam logic [31:0] REAL_SPAN  = 32'(REAL_BYTES);
    localparam logic [31:0] ALIAS_SPAN = 32'(REAL_BYTES) << 5;

    logic [31:0] real_off;
    logic [31:0] alias_off;

    always_comb begin
        // Unsigned wrap makes addresses below a base look huge, so one compare suffices.
        real_off  = addr - REAL_BASE;
        alias_off = addr - ALIAS_BASE;
        hit_alias = alias_off < ALIAS_SPAN;
        hit_real  = (real_off < REAL_SPAN) && !hit_alias;
        bitpos    = alias_off[4:2];
        byte_off  = hit_alias ? alias_off[BW+4:5] : real_off[BW-1:0];
    end
endmodule

// File: rtl/bb_lane_gen.sv
module bb_lane_gen
    import bb_pkg::*;
(
    input  logic [1:0]  size,
    input  logic [1:0]  lane,
    input  logic [31:0] wdata,
    output logic [3:0]  be,
    output logic [31:0] wdata_lanes
);
    always_comb begin
        case (size)
            SZ_BYTE: begin
                be          = 4'b0001 << lane;
                wdata_lanes = {4{wdata[7:0]}};
            end
            SZ_HALF: begin
                be          = lane[1] ? 4'b1100 : 4'b0011;
                wdata_lanes = {2{wdata[15:0]}};
            end
            default: begin
                be          = 4'b1111;
                wdata_lanes = wdata;
            end
        endcase
    end
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge (
    input  logic [31:0] old_word,
    input  logic [1:0]  lane,
    input  logic [2:0]  bitpos,
    input  logic        newbit,
    output logic [31:0] merged,
    output logic        picked
);
    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [7:0] mask;
        assign mask = (lane == 2'(g)) ? (8'b1 << bitpos) : 8'h00;
        assign merged[g*8 +: 8] = (old_word[g*8 +: 8] & ~mask) | (newbit ? mask : 8'h00);
    end

    assign picked = old_word[{lane, bitpos}];
endmodule

// File: rtl/bitband_alias_unit.sv
module bitband_alias_unit
    import bb_pkg::*;
#(
    parameter logic [31:0] REAL_BASE  = 32'h2000_0000,
    parameter logic [31:0] ALIAS_BASE = 32'h2200_0000,
    parameter int unsigned REAL_BYTES = 4096,
    localparam int BW = $clog2(REAL_BYTES),
    localparam int AW = BW - 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          m_req,
    input  logic          m_we,
    input  logic [1:0]    m_size,
    input  logic [31:0]   m_addr,
    input  logic [31:0]   m_wdata,
    output logic          m_ready,
    output logic          m_rvalid,
    output logic [31:0]   m_rdata,
    output logic          sram_en,
    output logic          sram_we,
    output logic [3:0]    sram_be,
    output logic [AW-1:0] sram_addr,
    output logic [31:0]   sram_wdata,
    input  logic [31:0]   sram_rdata
);
    typedef struct packed {
        bb_state_e     state;
        logic          rvalid;
        bb_resp_e      resp;
        logic          resp_bit;
        logic [AW-1:0] tgt_word;
        logic [1:0]    tgt_lane;
        logic [2:0]    tgt_bit;
        logic          tgt_val;
    } regs_t;

    regs_t r_d, r_q;

    logic          hit_real, hit_alias;
    logic [BW-1:0] byte_off;
    logic [2:0]    bitpos;
    logic [AW-1:0] cur_word;
    logic [1:0]    cur_lane;
    logic [3:0]    lane_be;
    logic [31:0]   lane_data;
    logic [31:0]   merged_word;
    logic          picked_bit;
    logic          accept;

    bb_addr_decode #(
        .REAL_BASE (REAL_BASE),
        .ALIAS_BASE(ALIAS_BASE),
        .REAL_BYTES(REAL_BYTES)
    ) u_dec (
        .addr     (m_addr),
        .hit_real (hit_real),
        .hit_alias(hit_alias),
        .byte_off (byte_off),
        .bitpos   (bitpos)
    );

    assign cur_word = byte_off[BW-1:2];
    assign cur_lane = byte_off[1:0];

    bb_lane_gen u_lanes (
        .size       (m_size),
        .lane       (cur_lane),
        .wdata      (m_wdata),
        .be         (lane_be),
        .wdata_lanes(lane_data)
    );

    bb_bit_merge u_merge (
        .old_word(sram_rdata),
        .lane    (r_q.tgt_lane),
        .bitpos  (r_q.tgt_bit),
        .newbit  (r_q.tgt_val),
        .merged  (merged_word),
        .picked  (picked_bit)
    );

    assign m_ready = (r_q.state == ST_IDLE);
    assign accept  = m_req && m_ready;

    // Next-state computation
    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (accept) begin
                    if (hit_alias) begin
                        r_d.tgt_word = cur_word;
                        r_d.tgt_lane = cur_lane;
                        r_d.tgt_bit  = bitpos;
                        r_d.tgt_val  = m_wdata[0];
                        r_d.state    = m_we ? ST_ALIAS_WB : ST_ALIAS_RD;
                    end else if (!m_we) begin
                        r_d.rvalid = 1'b1;
                        r_d.resp   = hit_real ? RSP_SRAM : RSP_ZERO;
                    end
                end
            end
            ST_ALIAS_RD: begin
                r_d.resp_bit = picked_bit;
                r_d.resp     = RSP_BIT;
                r_d.rvalid   = 1'b1;
                r_d.state    = ST_IDLE;
            end
            ST_ALIAS_WB: begin
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, resp: RSP_ZERO, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    // SRAM port drive
    always_comb begin
        sram_en    = 1'b0;
        sram_we    = 1'b0;
        sram_be    = 4'b0000;
        sram_addr  = (r_q.state == ST_IDLE) ? cur_word : r_q.tgt_word;
        sram_wdata = lane_data;
        if (r_q.state == ST_IDLE) begin
            if (accept && (hit_real || hit_alias)) begin
                sram_en = 1'b1;
                sram_we = m_we && hit_real;
                sram_be = (m_we && hit_real) ? lane_be : 4'b0000;
            end
        end else if (r_q.state == ST_ALIAS_WB) begin
            sram_en    = 1'b1;
            sram_we    = 1'b1;
            sram_be    = 4'b0001 << r_q.tgt_lane;
            sram_wdata = merged_word;
        end
    end

    always_comb begin
        unique case (r_q.resp)
            RSP_SRAM: m_rdata = sram_rdata;
            RSP_BIT:  m_rdata = {31'b0, r_q.resp_bit};
            default:  m_rdata = 32'b0;
        endcase
    end
    assign m_rvalid = r_q.rvalid;

    // Checks
    assert_alias_locks_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept && hit_alias |=> !m_ready);

    assert_alias_wb_one_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept && hit_alias && m_we |=>
            sram_en && sram_we && $countones(sram_be) == 1 && sram_addr == $past(cur_word));

    assert_alias_read_zero_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept && hit_alias && !m_we |=> ##1 (m_rvalid && m_rdata[31:1] == 31'b0));

    assert_direct_read_no_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept && hit_real && !m_we |=> m_rvalid && m_ready);

    assert_outside_not_forwarded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !hit_real && !hit_alias |-> !sram_en);
endmodule

// File: tb/bitband_alias_unit_tb_top.sv
module bitband_alias_unit_tb_top;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          m_req = 1'b0;
    logic          m_we = 1'b0;
    logic [1:0]    m_size = 2'd2;
    logic [31:0]   m_addr = 32'h0;
    logic [31:0]   m_wdata = 32'h0;
    logic          m_ready, m_rvalid;
    logic [31:0]   m_rdata;
    logic          sram_en, sram_we;
    logic [3:0]    sram_be;
    logic [AW-1:0] sram_addr;
    logic [31:0]   sram_wdata;
    logic [31:0]   sram_rdata = 32'h0;
    logic [31:0]   mem [1024];

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    bitband_alias_unit dut_i (
        .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_size(m_size),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_ready(m_ready), .m_rvalid(m_rvalid),
        .m_rdata(m_rdata), .sram_en(sram_en), .sram_we(sram_we), .sram_be(sram_be),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
    );

    always @(posedge clk) begin
        if (sram_en) begin
            if (sram_we) begin
                for (int b = 0; b < 4; b++)
                    if (sram_be[b]) mem[sram_addr][b*8 +: 8] <= sram_wdata[b*8 +: 8];
            end else begin
                sram_rdata <= mem[sram_addr];
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // One bus access; reports read data, latency to rvalid, sram_en at accept, ready after accept
    task automatic bus(input logic we, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] wd, output logic [31:0] rd, output int lat,
                       output logic en_acc, output logic rdy_after);
        @(negedge clk);
        m_req = 1'b1; m_we = we; m_size = sz; m_addr = a; m_wdata = wd;
        while (!m_ready) @(negedge clk);
        en_acc = sram_en;
        @(posedge clk);
        #1 m_req = 1'b0;
        @(negedge clk);
        rdy_after = m_ready;
        lat = 1;
        rd = 32'h0;
        if (!we) begin
            while (!m_rvalid && lat < 5) begin
                @(negedge clk);
                lat++;
            end
            rd = m_rdata;
        end
    endtask

    task automatic wr(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] wd);
        logic [31:0] rd; int lat; logic e, r;
        bus(1'b1, sz, a, wd, rd, lat, e, r);
    endtask

    task automatic rdw(input logic [31:0] a, output logic [31:0] rd, output int lat);
        logic e, r;
        bus(1'b0, 2'd2, a, 32'h0, rd, lat, e, r);
    endtask

    task automatic t_reset;
        chk("R8 ready", 32'(m_ready), 32'd1);
        chk("R8 rvalid", 32'(m_rvalid), 32'd0);
        chk("R8 sram_en", 32'(sram_en), 32'd0);
    endtask

    task automatic t_direct_word;
        logic [31:0] rd; int lat; logic e, r;
        wr(2'd2, 32'h2000_0000, 32'hCAFE_F00D);
        wr(2'd2, 32'h2000_0FFC, 32'h1234_5678);
        bus(1'b0, 2'd2, 32'h2000_0000, 32'h0, rd, lat, e, r);
        chk("R6 word read", rd, 32'hCAFE_F00D);
        chk("R6 latency", 32'(lat), 32'd1);
        chk("R6 ready kept", 32'(r), 32'd1);
        rdw(32'h2000_0FFC, rd, lat);
        chk("R6 top word", rd, 32'h1234_5678);
    endtask

    task automatic t_direct_sizes;
        logic [31:0] rd; int lat;
        wr(2'd2, 32'h2000_0300, 32'h1122_3344);
        wr(2'd0, 32'h2000_0301, 32'h0000_00AA);
        rdw(32'h2000_0300, rd, lat);
        chk("R5 byte lane1", rd, 32'h1122_AA44);
        wr(2'd1, 32'h2000_0302, 32'hFFFF_BEEF);
        rdw(32'h2000_0300, rd, lat);
        chk("R5 half upper", rd, 32'hBEEF_AA44);
    endtask

    task automatic t_alias_read;
        logic [31:0] rd; int lat;
        rdw(32'h2200_6008, rd, lat);
        chk("R1 example bit2 set", rd, 32'h1);
        chk("R2 latency", 32'(lat), 32'd2);
        rdw(32'h2200_6000, rd, lat);
        chk("R2 bit0 clear", rd, 32'h0);
        rdw(32'h2200_6018, rd, lat);
        chk("R1 bit6 set", rd, 32'h1);
    endtask

    task automatic t_alias_write;
        logic [31:0] rd; int lat; logic e, r;
        bus(1'b1, 2'd2, 32'h2200_6008, 32'h0, rd, lat, e, r);
        chk("R4 ready low after alias", 32'(r), 32'd0);
        rdw(32'h2000_0300, rd, lat);
        chk("R3 clear bit2", rd, 32'hBEEF_AA40);
        wr(2'd2, 32'h2200_603C, 32'hFFFF_FFFE);
        rdw(32'h2000_0300, rd, lat);
        chk("R3 upper data ignored", rd, 32'hBEEF_2A40);
        wr(2'd2, 32'h2200_6060, 32'h0000_0001);
        rdw(32'h2000_0300, rd, lat);
        chk("R3 set bit in lane3", rd, 32'hBFEF_2A40);
    endtask

    task automatic t_sweep;
        logic [31:0] rd; int lat;
        for (int i = 0; i < 8; i++) begin
            wr(2'd2, 32'h2200_0200 + 32'(4*i), 32'h1);
            rdw(32'h2000_0010, rd, lat);
            chk("R1 sweep direct", rd, (32'h1 << (i + 1)) - 32'h1);
            rdw(32'h2200_0200 + 32'(4*i), rd, lat);
            chk("R2 sweep alias", rd, 32'h1);
        end
    endtask

    task automatic t_window;
        logic [31:0] rd; int lat; logic e, r;
        wr(2'd2, 32'h2201_FFFC, 32'h1);
        rdw(32'h2000_0FFC, rd, lat);
        chk("R9 last byte via alias", rd, 32'h9234_5678);
        rdw(32'h2201_FFFC, rd, lat);
        chk("R9 last alias read", rd, 32'h1);
        bus(1'b1, 2'd2, 32'h2000_1000, 32'hFFFF_FFFF, rd, lat, e, r);
        chk("R7 R9 past real no enable", 32'(e), 32'd0);
        bus(1'b1, 2'd2, 32'h2202_0000, 32'hFFFF_FFFF, rd, lat, e, r);
        chk("R7 R9 past alias no enable", 32'(e), 32'd0);
        bus(1'b0, 2'd2, 32'h2000_1000, 32'h0, rd, lat, e, r);
        chk("R7 outside read zero", rd, 32'h0);
        chk("R7 outside latency", 32'(lat), 32'd1);
        chk("R7 outside read no enable", 32'(e), 32'd0);
        rdw(32'h1FFF_FFFC, rd, lat);
        chk("R7 below base zero", rd, 32'h0);
        rdw(32'h2000_0000, rd, lat);
        chk("R7 no wrap into SRAM", rd, 32'hCAFE_F00D);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_direct_word();
        t_direct_sizes();
        t_alias_read();
        t_alias_write();
        t_sweep();
        t_window();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule